// File: doc/BRIEF.md
# Masked Vector Lane Dispatcher

This block spreads one scalar floating-point operation over a vector of 64-bit elements and assembles the destination under a write mask. A single request carries the source vector, the previous destination contents, an 8-bit lane mask with its enable, a choice between merging and zeroing for lanes that are not selected, a broadcast flag with a flag saying the source came from memory, a vector-length code and a reserved 4-bit specifier field. One cycle later the block presents the full 512-bit destination with a write strobe, along with the ORed exception flags of the lanes that were computed.

Each lane has its own scalar unit. The lane function is chosen at build time through a parameter. The default function flushes subnormal inputs to a signed zero, quiets NaNs and passes every other value through unchanged. A request with a bad specifier field or a reserved length code is reported as undefined. Such a request writes nothing and raises no flags.

Top module: `lane_dispatch`

## Requirements
- R1: A request on `valid_i` produces a one-cycle pulse on `res_vld_o` in the next cycle. `dst_o` changes only in a cycle where `res_vld_o` is high.
- R2: Length code `vlen_i` 0, 1 and 2 selects 2, 4 and 8 active 64-bit lanes (128, 256 and 512 bits).
- R3: An active lane j is computed when `mask_en_i` is 0 or when `mask_i[j]` is 1.
- R4: An active lane that is not computed takes `old_dst_i` lane j when `zero_mode_i` is 0, and takes zero when `zero_mode_i` is 1.
- R5: When `bcast_i` and `src_mem_i` are both 1, every computed lane uses source bits [63:0]. Otherwise lane j uses source bits [64j+63:64j].
- R6: Every destination bit at or above 64 times the active lane count is zero.
- R7: A request with `spec_i` not equal to 4'b1111, or with `vlen_i` equal to 3, gives `res_undef_o`=1 and `res_we_o`=0, and leaves `dst_o` and both flags unchanged and zero respectively.
- R8: `invalid_o` is the OR over the computed lanes of "input is a signalling NaN" (exponent all ones, fraction nonzero, fraction bit 51 clear). `inexact_o` is the OR over the computed lanes of "input is subnormal" (exponent zero, fraction nonzero).
- R9: The default lane function returns a NaN input with fraction bit 51 set, returns a subnormal input as zero with its sign kept, and returns every other input unchanged.
- R10: While reset is held, and until the first request, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| src_i | input | 512 | Source vector, lane j at [64j+63:64j] |
| old_dst_i | input | 512 | Previous destination contents used for merging |
| mask_i | input | 8 | Per-lane write mask |
| mask_en_i | input | 1 | 1 applies the mask, 0 computes all active lanes |
| zero_mode_i | input | 1 | 1 zeroes unselected lanes, 0 merges them |
| bcast_i | input | 1 | Broadcast element 0 request |
| src_mem_i | input | 1 | Source operand came from memory |
| vlen_i | input | 2 | Vector length code (0:128, 1:256, 2:512, 3:reserved) |
| spec_i | input | 4 | Reserved specifier field, must be all ones |
| res_vld_o | output | 1 | Result strobe, one cycle after the request |
| res_we_o | output | 1 | Destination write enable for this result |
| res_undef_o | output | 1 | Request was undefined |
| dst_o | output | 512 | Destination vector |
| invalid_o | output | 1 | Invalid flag over the computed lanes |
| inexact_o | output | 1 | Inexact flag over the computed lanes |

## Verification
The hardest case to reach from the ports is a set of flags that depends on exactly which lanes were computed. The special value has to sit in a lane that the mask turns off or that lies beyond the vector length, and it must not raise a flag. The stimulus rotates six value classes (normal, subnormal, signalling NaN, quiet NaN, zero, infinity) across the lanes with an offset that changes per request. It then sweeps all 256 mask patterns under every length, masking mode and broadcast/memory pairing, so each class lands in masked, unmasked and out-of-range lanes. Broadcast with a non-memory source is mixed in so that lane 0 values do not leak into other lanes.

// File: rtl/lane_disp_pkg.sv
package lane_disp_pkg;

  typedef enum logic [1:0] {
    LOP_FTZ = 2'd0,
    LOP_NEG = 2'd1,
    LOP_ABS = 2'd2
  } lane_op_e;

  localparam int unsigned ELEM_W    = 64;
  localparam int unsigned EXP_MSB   = 62;
  localparam int unsigned EXP_LSB   = 52;
  localparam int unsigned QUIET_BIT = 51;

  function automatic logic fp_is_nan(input logic [ELEM_W-1:0] v);
    return (&v[EXP_MSB:EXP_LSB]) && (|v[EXP_LSB-1:0]);
  endfunction

  function automatic logic fp_is_snan(input logic [ELEM_W-1:0] v);
    return fp_is_nan(v) && !v[QUIET_BIT];
  endfunction

  function automatic logic fp_is_sub(input logic [ELEM_W-1:0] v);
    return !(|v[EXP_MSB:EXP_LSB]) && (|v[EXP_LSB-1:0]);
  endfunction

endpackage

// File: rtl/lane_rst_sync.sv
module lane_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s = sync_q[1];
endmodule

// File: rtl/lane_src_sel.sv
module lane_src_sel #(
  parameter int unsigned LANES = 8,
  parameter int unsigned EW    = 64,
  localparam int unsigned VW   = LANES * EW
) (
  input  logic          bcast_eff,
  input  logic [VW-1:0] src,
  output logic [VW-1:0] lane_src
);
  for (genvar j = 0; j < LANES; j++) begin : g_sel
    if (j == 0) begin : g_first
      assign lane_src[EW-1:0] = src[EW-1:0];
    end else begin : g_rest
      assign lane_src[j*EW +: EW] = bcast_eff ? src[EW-1:0] : src[j*EW +: EW];
    end
  end
endmodule

// File: rtl/lane_scalar.sv
module lane_scalar
  import lane_disp_pkg::*;
#(
  parameter lane_op_e OP = LOP_FTZ
) (
  input  logic [ELEM_W-1:0] a,
  output logic [ELEM_W-1:0] res,
  output logic              inv,
  output logic              inx
);
  logic is_nan;
  logic is_snan;
  logic is_sub;
  logic [ELEM_W-1:0] quiet_v;

  always_comb begin
    is_nan  = fp_is_nan(a);
    is_snan = fp_is_snan(a);
    is_sub  = fp_is_sub(a);
    quiet_v = a;
    quiet_v[QUIET_BIT] = 1'b1;
  end

  if (OP == LOP_NEG) begin : g_neg
    always_comb begin
      res = is_nan ? quiet_v : {~a[ELEM_W-1], a[ELEM_W-2:0]};
      inv = is_snan;
      inx = 1'b0;
    end
  end else if (OP == LOP_ABS) begin : g_abs
    always_comb begin
      res = is_nan ? quiet_v : {1'b0, a[ELEM_W-2:0]};
      inv = is_snan;
      inx = 1'b0;
    end
  end else begin : g_ftz
    always_comb begin
      if (is_nan)      res = quiet_v;
      else if (is_sub) res = {a[ELEM_W-1], {(ELEM_W-1){1'b0}}};
      else             res = a;
      inv = is_snan;
      inx = is_sub;
    end
  end
endmodule

// File: rtl/lane_compose.sv
module lane_compose #(
  parameter int unsigned LANES = 8,
  parameter int unsigned EW    = 64,
  localparam int unsigned VW   = LANES * EW
) (
  input  logic [VW-1:0]    lane_res,
  input  logic [VW-1:0]    old_dst,
  input  logic [LANES-1:0] lane_on,
  input  logic [LANES-1:0] lane_cmp,
  input  logic             zero_mode,
  output logic [VW-1:0]    dst
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      if (!lane_on[j])      dst[j*EW +: EW] = '0;
      else if (lane_cmp[j]) dst[j*EW +: EW] = lane_res[j*EW +: EW];
      else if (zero_mode)   dst[j*EW +: EW] = '0;
      else                  dst[j*EW +: EW] = old_dst[j*EW +: EW];
    end
  end
endmodule

// File: rtl/lane_dispatch.sv
module lane_dispatch
  import lane_disp_pkg::*;
#(
  parameter int unsigned MAX_LANES = 8,
  parameter lane_op_e    LANE_OP   = LOP_FTZ,
  localparam int unsigned EW       = ELEM_W,
  localparam int unsigned VW       = MAX_LANES * EW,
  localparam int unsigned CNT_W    = $clog2(MAX_LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic [VW-1:0]        src_i,
  input  logic [VW-1:0]        old_dst_i,
  input  logic [MAX_LANES-1:0] mask_i,
  input  logic                 mask_en_i,
  input  logic                 zero_mode_i,
  input  logic                 bcast_i,
  input  logic                 src_mem_i,
  input  logic [1:0]           vlen_i,
  input  logic [3:0]           spec_i,
  output logic                 res_vld_o,
  output logic                 res_we_o,
  output logic                 res_undef_o,
  output logic [VW-1:0]        dst_o,
  output logic                 invalid_o,
  output logic                 inexact_o
);
  logic rst_s;

  lane_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  // request decode
  logic [CNT_W-1:0]     n_act;
  logic                 undef;
  logic [MAX_LANES-1:0] lane_on;
  logic [MAX_LANES-1:0] lane_cmp;
  logic                 bcast_eff;

  always_comb begin
    undef = (spec_i != 4'b1111) || (vlen_i == 2'd3);
    n_act = undef ? '0 : (CNT_W'(2) << vlen_i);
    for (int j = 0; j < MAX_LANES; j++) begin
      lane_on[j] = (CNT_W'(j) < n_act);
    end
    lane_cmp  = lane_on & (mask_en_i ? mask_i : {MAX_LANES{1'b1}});
    bcast_eff = bcast_i && src_mem_i;
  end

  // lane datapath
  logic [VW-1:0]        lane_src;
  logic [VW-1:0]        lane_res;
  logic [MAX_LANES-1:0] lane_inv;
  logic [MAX_LANES-1:0] lane_inx;
  logic [VW-1:0]        dst_comb;

  lane_src_sel #(.LANES(MAX_LANES), .EW(EW)) i_sel (
    .bcast_eff (bcast_eff),
    .src       (src_i),
    .lane_src  (lane_src)
  );

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_unit
    lane_scalar #(.OP(LANE_OP)) i_unit (
      .a   (lane_src[j*EW +: EW]),
      .res (lane_res[j*EW +: EW]),
      .inv (lane_inv[j]),
      .inx (lane_inx[j])
    );
  end

  lane_compose #(.LANES(MAX_LANES), .EW(EW)) i_cmp (
    .lane_res  (lane_res),
    .old_dst   (old_dst_i),
    .lane_on   (lane_on),
    .lane_cmp  (lane_cmp),
    .zero_mode (zero_mode_i),
    .dst       (dst_comb)
  );

  // next state
  logic                 vld_d, we_d, undef_d, inv_d, inx_d;
  logic                 dst_ce, flag_ce;
  logic [CNT_W-1:0]     act_q;
  logic [MAX_LANES-1:0] cmp_q;
  logic                 zero_q;

  always_comb begin
    vld_d   = valid_i;
    we_d    = valid_i && !undef;
    undef_d = valid_i && undef;
    dst_ce  = valid_i && !undef;
    flag_ce = valid_i;
    inv_d   = !undef && (|(lane_inv & lane_cmp));
    inx_d   = !undef && (|(lane_inx & lane_cmp));
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      res_vld_o   <= 1'b0;
      res_we_o    <= 1'b0;
      res_undef_o <= 1'b0;
    end else begin
      res_vld_o   <= vld_d;
      res_we_o    <= we_d;
      res_undef_o <= undef_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else if (flag_ce) begin
      invalid_o <= inv_d;
      inexact_o <= inx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      dst_o  <= '0;
      act_q  <= '0;
      cmp_q  <= '0;
      zero_q <= 1'b0;
    end else if (dst_ce) begin
      dst_o  <= dst_comb;
      act_q  <= n_act;
      cmp_q  <= lane_cmp;
      zero_q <= zero_mode_i;
    end
  end

  // assertions
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_s)
    valid_i |=> res_vld_o);  // R1

  AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    !res_vld_o |-> $stable(dst_o));  // R1

  AST_UNDEF_NO_WE: assert property (@(posedge clk) disable iff (!rst_s)
    res_undef_o |-> !res_we_o);  // R7

  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    (res_vld_o && !res_we_o) |-> (!invalid_o && !inexact_o));  // R8

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_chk
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_s)
      (res_we_o && (CNT_W'(j) >= act_q)) |-> (dst_o[j*EW +: EW] == '0));  // R6

    AST_ZERO_MASKED: assert property (@(posedge clk) disable iff (!rst_s)
      (res_we_o && zero_q && !cmp_q[j]) |-> (dst_o[j*EW +: EW] == '0));  // R4
  end
endmodule

// File: tb/test_lane_dispatch.sv
module test_lane_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int L = 8;
  localparam int VW = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [VW-1:0] src_i = '0;
  logic [VW-1:0] old_dst_i = '0;
  logic [L-1:0] mask_i = '0;
  logic mask_en_i = 1'b0, zero_mode_i = 1'b0, bcast_i = 1'b0, src_mem_i = 1'b0;
  logic [1:0] vlen_i = 2'd0;
  logic [3:0] spec_i = 4'hF;
  logic res_vld_o, res_we_o, res_undef_o, invalid_o, inexact_o;
  logic [VW-1:0] dst_o;

  int checks = 0;
  int failures = 0;

  logic          e_vld = 1'b0, e_we = 1'b0, e_undef = 1'b0, e_inv = 1'b0, e_inx = 1'b0;
  logic [VW-1:0] e_dst = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_dispatch i_lane_dispatch (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .src_i(src_i),
    .old_dst_i(old_dst_i), .mask_i(mask_i), .mask_en_i(mask_en_i),
    .zero_mode_i(zero_mode_i), .bcast_i(bcast_i), .src_mem_i(src_mem_i),
    .vlen_i(vlen_i), .spec_i(spec_i), .res_vld_o(res_vld_o),
    .res_we_o(res_we_o), .res_undef_o(res_undef_o), .dst_o(dst_o),
    .invalid_o(invalid_o), .inexact_o(inexact_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_elem(input int k);
    logic [63:0] v;
    case (k % 6)
      0: v = 64'h3FF8_0000_0000_0000 + 64'(k);
      1: v = {k[0], 11'd0, 52'h0_1234_0000_0000 + 52'(k)};
      2: v = 64'h7FF0_0000_0000_0001 + 64'(k);
      3: v = 64'hFFF8_0000_0000_0000 + 64'(k);
      4: v = {k[1], 63'd0};
      default: v = {k[0], 11'h7FF, 52'd0};
    endcase
    return v;
  endfunction

  task automatic ref_lane(input logic [63:0] a, output logic [63:0] r, output logic inv, output logic inx);
    logic nan, sub;
    nan = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
    sub = (a[62:52] == 11'h000) && (a[51:0] != 0);
    inv = nan && !a[51];
    inx = sub;
    if (nan) begin r = a; r[51] = 1'b1; end
    else if (sub) r = {a[63], 63'd0};
    else r = a;
  endtask

  // compare the registered outputs with the model's prediction
  task automatic compare_now();
    chk(res_vld_o === e_vld, "R1 res_vld_o", VW'(res_vld_o), VW'(e_vld));
    chk(res_we_o === e_we, "R7 res_we_o", VW'(res_we_o), VW'(e_we));
    chk(res_undef_o === e_undef, "R7 res_undef_o", VW'(res_undef_o), VW'(e_undef));
    chk(dst_o === e_dst, "R2 R3 R4 R5 R6 R9 dst_o", dst_o, e_dst);
    chk(invalid_o === e_inv, "R8 invalid_o", VW'(invalid_o), VW'(e_inv));
    chk(inexact_o === e_inx, "R8 inexact_o", VW'(inexact_o), VW'(e_inx));
  endtask

  // drive one cycle (at negedge) and update the model for the next edge
  task automatic step(input logic v, input logic [1:0] vl, input logic z, input logic bc,
                      input logic mem, input logic men, input logic [7:0] m,
                      input logic [3:0] sp, input int seed);
    logic [VW-1:0] s, o, d;
    logic [63:0] r;
    logic li, lx, fi, fx, cmp;
    int n;
    for (int j = 0; j < L; j++) begin
      s[j*64 +: 64] = mk_elem(seed + j * 7 + (seed / 5));
      o[j*64 +: 64] = {$urandom, $urandom};
    end
    valid_i = v; vlen_i = vl; zero_mode_i = z; bcast_i = bc; src_mem_i = mem;
    mask_en_i = men; mask_i = m; spec_i = sp; src_i = s; old_dst_i = o;
    e_vld = v;
    if (!v) begin
      e_we = 1'b0; e_undef = 1'b0;
    end else if (sp != 4'hF || vl == 2'd3) begin
      e_we = 1'b0; e_undef = 1'b1; e_inv = 1'b0; e_inx = 1'b0;
    end else begin
      n = 2 << vl;
      fi = 1'b0; fx = 1'b0; d = '0;
      for (int j = 0; j < L; j++) begin
        if (j < n) begin
          cmp = !men || m[j];
          if (cmp) begin
            ref_lane((bc && mem) ? s[63:0] : s[j*64 +: 64], r, li, lx);
            d[j*64 +: 64] = r;
            fi = fi | li; fx = fx | lx;
          end else if (!z) begin
            d[j*64 +: 64] = o[j*64 +: 64];
          end
        end
      end
      e_we = 1'b1; e_undef = 1'b0; e_dst = d; e_inv = fi; e_inx = fx;
    end
    @(negedge clk);
    compare_now();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 0;
    repeat (3) @(negedge clk);
    // R10: outputs zero under reset
    compare_now();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_now();
    // full mask sweep: R2 R3 R4 R5 R6 R8 R9
    for (int vl = 0; vl < 3; vl++)
      for (int z = 0; z < 2; z++)
        for (int bm = 0; bm < 4; bm++)
          for (int m = 0; m < 256; m++) begin
            step(1'b1, 2'(vl), 1'(z), bm[0], bm[1], 1'b1, 8'(m), 4'hF, seed);
            seed++;
            if (m % 37 == 0) step(1'b0, 2'(vl), 1'(z), bm[0], bm[1], 1'b1, 8'(m), 4'hF, seed);
          end
    // masking disabled: R3
    for (int vl = 0; vl < 3; vl++)
      for (int z = 0; z < 2; z++)
        for (int bm = 0; bm < 4; bm++)
          for (int k = 0; k < 6; k++) begin
            step(1'b1, 2'(vl), 1'(z), bm[0], bm[1], 1'b0, 8'($urandom), 4'hF, seed);
            seed++;
          end
    // undefined requests: R7
    for (int k = 0; k < 30; k++) begin
      step(1'b1, 2'(k % 3), 1'(k % 2), 1'b1, 1'b1, 1'b0, 8'hFF, 4'(k % 15), seed);
      seed++;
      step(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 4'hF, seed);
      seed++;
      step(1'b1, 2'(k % 3), 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'hF, seed);
      seed++;
    end
    step(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'hF, seed);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule